// File: doc/BRIEF.md
# Double-Buffered Serial Receiver with Address Wake-Up

This block takes one asynchronous serial line and turns it into characters that a processor can read. Bits are gathered in an internal shift stage. Software never sees that stage. When a whole character has arrived, it moves into a readable holding register and a one-cycle receive pulse is raised. While the holding register waits to be read, the shift stage is already free to assemble the next character. A character that finishes while the holding register is still unread sets a sticky overrun flag and is thrown away. The older character stays in place.

Four character formats are supported. The first two are plain 7-bit and plain 8-bit characters. The third is 8 bits plus a parity bit. The fourth is a 9-bit word. In the last two formats the extra bit goes into a separate flag. In 9-bit format an address wake-up option can be switched on. With it on, a character whose ninth bit is clear is ignored completely, so a listening node is disturbed only by address characters. The line is sampled on a 16x oversampling enable that the baud generator supplies. That generator and the transmit direction sit outside this block.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset, rx_data, rx_bit9, rx_full, rx_overrun, rx_ferr and rx_irq are all 0.
- R2: A character begins only when the line goes from 1 to 0 between two oversample ticks and is still 0 on the 8th tick, counting the tick that saw the transition. A low pulse that ends before that tick produces no character.
- R3: Data bits arrive LSB first, one every 16 ticks. The `mode` input selects the format: 0 = 7 data bits, 1 = 8 data bits, 2 = 8 data bits plus parity, 3 = 9-bit word. In mode 0, rx_data[7] reads 0.
- R4: rx_bit9 takes the bit that follows the 8 data bits in modes 2 and 3, which is the parity bit or the word MSB. In modes 0 and 1 it takes 0.
- R5: An accepted character loads rx_data, rx_bit9 and rx_ferr, and sets rx_full. On the clock after the load, rx_irq is high for exactly one cycle.
- R6: A one-cycle rd_strobe clears rx_full. If rd_strobe comes in the same cycle that a character completes, the new character is accepted.
- R7: If a character completes while rx_full is set and no read is happening, rx_overrun is set. rx_data, rx_bit9, rx_ferr and rx_full do not change, and no rx_irq is raised.
- R8: Once set, rx_overrun stays set through reads and later characters. Only ovr_clr clears it. A new overrun in the same cycle as ovr_clr keeps it set.
- R9: A stop bit sampled as 0 sets rx_ferr together with the load. The character is still delivered. A stop bit sampled as 1 clears rx_ferr with the load.
- R10: With wake_en high in mode 3, a character whose ninth bit is 0 changes no output and raises no rx_irq, and it cannot cause an overrun. A character whose ninth bit is 1 is handled as normal.
- R11: A new character can be received while the holding register is full. If it is read before the next stop sample, the new character is accepted without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high, already synchronised |
| mode | input | 2 | Character format: 0 = 7-bit, 1 = 8-bit, 2 = 8-bit plus parity, 3 = 9-bit |
| wake_en | input | 1 | Address wake-up filter, active in mode 3 |
| rd_strobe | input | 1 | Processor read of the holding register |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_data | output | 8 | Holding register |
| rx_bit9 | output | 1 | Parity bit or ninth bit of the held character |
| rx_full | output | 1 | Holding register contains an unread character |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_ferr | output | 1 | Stop bit of the held character was 0 |
| rx_irq | output | 1 | One-cycle receive pulse |

## Verification
The embedded properties rely on three things. First, `mode` and `wake_en` stay fixed while a character is in flight. Second, `os_tick` never stays high on two back-to-back clocks. Third, the read and clear strobes are each one cycle wide. The bench meets all three. It produces the tick as one clock in every four. It changes the format only between characters, after the line has been idle for some ticks. It drives every strobe for one cycle at a falling clock edge. Each bit is held for exactly 16 ticks, aligned to the tick that detects the start. Every sample point therefore lands well inside its bit.

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [1:0] mode,
  input  logic       wake_en,
  input  logic       rd_strobe,
  input  logic       ovr_clr,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_full,
  output logic       rx_overrun,
  output logic       rx_ferr,
  output logic       rx_irq
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;
  st_t        st;
  logic [CW-1:0] cnt;
  logic [3:0] bitn;
  logic [8:0] sh;
  logic       prev;

  logic [3:0] nbits;
  logic [7:0] word;
  logic       ninth, done, drop, accept, ovr_ev;

  assign nbits = (mode == 2'd0) ? 4'd7 : (mode == 2'd1) ? 4'd8 : 4'd9;
  assign word  = (mode == 2'd0) ? {1'b0, sh[8:2]} : (mode == 2'd1) ? sh[8:1] : sh[7:0];
  assign ninth = mode[1] & sh[8];
  assign done  = os_tick && st == S_STOP && cnt == CW'(OSR - 1);
  assign drop  = mode == 2'd3 && wake_en && !sh[8];
  assign accept = done && !drop && (!rx_full || rd_strobe);
  assign ovr_ev = done && !drop && rx_full && !rd_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      prev <= 1'b1;
    end else if (os_tick) begin
      prev <= rxd;
      case (st)
        S_IDLE: if (prev && !rxd) begin
          st  <= S_START;
          cnt <= CW'(1);
        end
        S_START: if (cnt == CW'(HALF - 1)) begin
          st   <= rxd ? S_IDLE : S_DATA;
          cnt  <= '0;
          bitn <= '0;
        end else cnt <= cnt + 1'b1;
        S_DATA: if (cnt == CW'(OSR - 1)) begin
          cnt  <= '0;
          sh   <= {rxd, sh[8:1]};
          bitn <= bitn + 1'b1;
          if (bitn == nbits - 4'd1) st <= S_STOP;
        end else cnt <= cnt + 1'b1;
        S_STOP: if (cnt == CW'(OSR - 1)) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_bit9    <= 1'b0;
      rx_full    <= 1'b0;
      rx_overrun <= 1'b0;
      rx_ferr    <= 1'b0;
      rx_irq     <= 1'b0;
    end else begin
      rx_irq <= accept;
      if (accept) begin
        rx_data <= word;
        rx_bit9 <= ninth;
        rx_ferr <= !rxd;
        rx_full <= 1'b1;
      end else if (rd_strobe) begin
        rx_full <= 1'b0;
      end
      if (ovr_ev) rx_overrun <= 1'b1;
      else if (ovr_clr) rx_overrun <= 1'b0;
    end
  end

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full && $past(!rx_irq));
  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !os_tick |=> !rx_full);
  // R7
  overrun_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $stable(rx_data) && $stable(rx_bit9) && !rx_irq && $past(rx_full));
  // R8
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_overrun) |-> $past(ovr_clr));
  // R10
  wake_bit9_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && mode == 2'd3 && wake_en |-> rx_bit9);
  // R3
  narrow_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && mode == 2'd0 |-> !rx_data[7]);
endmodule

// File: tb/tb_uart_rx_dbuf.sv
module tb_uart_rx_dbuf;
  logic clk = 0, rst_n = 0, os_tick = 0, rxd = 1;
  logic [1:0] mode = 0;
  logic wake_en = 0, rd_strobe = 0, ovr_clr = 0;
  logic [7:0] rx_data;
  logic rx_bit9, rx_full, rx_overrun, rx_ferr, rx_irq;

  uart_rx_dbuf dut (.*);

  always #2.5 clk = ~clk;

  int div = 0;
  always @(posedge clk) begin
    div <= (div == 3) ? 0 : div + 1;
    os_tick <= (div == 2);
  end

  typedef struct { int dt; logic [8:0] v; int n; logic stopb; bit drop; logic [1:0] md; } ev_t;
  ev_t q[$];
  int tcount = 0;
  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] e_data = 0;
  logic e_bit9 = 0, e_full = 0, e_ovr = 0, e_ferr = 0, e_irq = 0;

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit acc, ovs;
    acc = 0; ovs = 0;
    if (!rst_n) begin
      e_data = 0; e_bit9 = 0; e_full = 0; e_ovr = 0; e_ferr = 0; e_irq = 0; q.delete();
    end else begin
      if (os_tick) begin
        tcount++;
        if (q.size() > 0 && q[0].dt == tcount) begin
          ev_t e;
          e = q.pop_front();
          if (!e.drop) begin
            if (e_full && !rd_strobe) begin
              ovs = 1;
            end else begin
              acc = 1;
              e_data = (e.n == 7) ? {1'b0, e.v[6:0]} : e.v[7:0];
              e_bit9 = (e.n == 9) ? e.v[8] : 1'b0;
              e_ferr = !e.stopb;
            end
          end
        end
      end
      if (acc) e_full = 1; else if (rd_strobe) e_full = 0;
      if (ovs) e_ovr = 1; else if (ovr_clr) e_ovr = 0;
      e_irq = acc;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R3 data", {1'b0, rx_data}, {1'b0, e_data});
    chk("R4 bit9", {8'b0, rx_bit9}, {8'b0, e_bit9});
    chk("R6 full", {8'b0, rx_full}, {8'b0, e_full});
    chk("R8 overrun", {8'b0, rx_overrun}, {8'b0, e_ovr});
    chk("R9 ferr", {8'b0, rx_ferr}, {8'b0, e_ferr});
    chk("R5 irq", {8'b0, rx_irq}, {8'b0, e_irq});
  end

  task automatic wait_tick(input int t);
    @(negedge clk);
    while (!(os_tick && tcount == t)) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] md, input logic [8:0] v, input logic stopb);
    int n, d;
    ev_t e;
    n = (md == 0) ? 7 : (md == 1) ? 8 : 9;
    @(negedge clk);
    while (!os_tick) @(negedge clk);
    rxd = 0;
    d = tcount + 1;
    e.dt = d + 7 + 16 * (n + 1); e.v = v; e.n = n; e.stopb = stopb; e.md = md;
    e.drop = (md == 3) && wake_en && !v[8];
    q.push_back(e);
    for (int j = 1; j <= n + 1; j++) begin
      wait_tick(d + 16 * j - 1);
      rxd = (j <= n) ? v[j-1] : stopb;
    end
    wait_tick(d + 16 * (n + 2) - 1);
    rxd = 1;
    wait_tick(d + 16 * (n + 2) + 2);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_strobe = 1; @(negedge clk); rd_strobe = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1; fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset", {rx_data, rx_full}, 9'h0);
    chk("R1 reset flags", {5'b0, rx_bit9, rx_overrun, rx_ferr, rx_irq}, 9'h0);
    repeat (8) @(negedge clk);

    mode = 1; send(1, 9'h0A5, 1);
    chk("R5 full after load", {8'b0, rx_full}, 9'h1);
    chk("R3 8-bit data", {1'b0, rx_data}, 9'h0A5);
    pulse_rd();
    chk("R6 read clears", {8'b0, rx_full}, 9'h0);

    mode = 0; send(0, 9'h0D3, 1);
    chk("R3 7-bit data", {1'b0, rx_data}, 9'h053);
    pulse_rd();

    mode = 2; send(2, 9'h1C3, 1);
    chk("R4 parity bit", {rx_bit9, rx_data}, 9'h1C3);
    pulse_rd();

    mode = 3; send(3, 9'h05A, 1);
    chk("R4 ninth bit clear", {rx_bit9, rx_data}, 9'h05A);
    pulse_rd();

    mode = 1; send(1, 9'h03C, 0);
    chk("R9 framing error", {rx_ferr, rx_data}, 9'h13C);
    pulse_rd();
    send(1, 9'h011, 1);
    chk("R9 ferr cleared", {rx_ferr, rx_data}, 9'h011);
    pulse_rd();

    // R2 glitch
    @(negedge clk); while (!os_tick) @(negedge clk);
    rxd = 0;
    wait_tick(tcount + 3);
    rxd = 1;
    repeat (400) @(negedge clk);
    chk("R2 glitch ignored", {8'b0, rx_full}, 9'h0);

    // R7 overrun
    send(1, 9'h077, 1);
    send(1, 9'h088, 1);
    chk("R7 old kept", {rx_overrun, rx_data}, 9'h177);
    pulse_rd();
    send(1, 9'h099, 1);
    chk("R8 overrun sticky", {rx_overrun, rx_data}, 9'h199);
    pulse_clr();
    chk("R8 overrun cleared", {8'b0, rx_overrun}, 9'h0);
    pulse_rd();

    // R11 read during next reception
    send(1, 9'h0E1, 1);
    fork
      send(1, 9'h01E, 1);
      begin repeat (150) @(negedge clk); pulse_rd(); end
    join
    chk("R11 second accepted", {rx_overrun, rx_data}, 9'h01E);
    pulse_rd();

    // R10 wake-up
    mode = 3; wake_en = 1;
    send(3, 9'h012, 1);
    chk("R10 data char ignored", {rx_full, rx_data}, 9'h01E);
    send(3, 9'h134, 1);
    chk("R10 address char", {rx_bit9, rx_data}, 9'h134);
    send(3, 9'h056, 1);
    chk("R10 no overrun from ignored", {rx_overrun, rx_data}, 9'h034);
    pulse_rd();

    repeat (20) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule